// File: doc/BRIEF.md
# SWD Link Bring-Up Sequencer

This block sits on the host side of a serial-wire debug link. It takes a debug port that powers up in JTAG mode and places it in two-wire SWD mode. It then confirms the link by reading the port's identification word. A single `start` pulse runs the whole bring-up. The block drives the clock and data lines directly for the raw, unframed part of the sequence. It then passes the lines to an external transaction engine, which performs one framed DP read.

The raw part runs in this order:
- a line reset of 56 clock cycles with the data line high, followed by 2 low idle cycles;
- the 16-bit mode-switch word 0xE79E, least significant bit first;
- a second 56-cycle high line reset, followed by 2 low idle cycles.

The serial clock runs at the same programmable rate the transaction engine uses. Each half period of the clock lasts `clk_div`+1 system clocks. When the engine reports that its read is complete, the block captures the returned word. It sets `done`, and it sets `success` only when the acknowledge was OK, the data parity was good and the word equals `expected_idcode`.

Top module: `swd_init_seq`

## Requirements
- R1: During and after reset, and whenever the block is neither running raw bits nor lending the lines to the engine, `swclk`=0, `swdio_out`=0, `swdio_oe`=1, `xact_req`=0, `done`=0 and `success`=0 until a sequence completes; `idcode` resets to 0.
- R2: The first 58 bits sampled on rising `swclk` edges are 56 ones followed by 2 zeros.
- R3: Bits 58 to 73 on rising edges are the word 0xE79E, least significant bit first.
- R4: Bits 74 to 131 are 56 ones followed by 2 zeros. The raw stream is exactly 132 rising edges long, and the read request follows it.
- R5: During the raw stream, every high and every low half period of `swclk` lasts `clk_div`+1 clock cycles. `swdio_out` changes only while `swclk` is low.
- R6: After the raw stream, `xact_req` rises with `xact_apndp`=0, `xact_rnw`=1 and `xact_addr`=2'b00. It stays high until the cycle in which `xact_done` is sampled, and then falls.
- R7: While `xact_req` is high, `swclk`, `swdio_out` and `swdio_oe` follow `eng_swclk`, `eng_swdio_out` and `eng_swdio_oe`. During the raw stream those engine inputs have no effect and `swdio_oe` stays 1.
- R8: On the cycle after `xact_done`, `done`=1. `success`=1 only if `xact_ack`=3'b001 (OK), `xact_parity_err`=0 and `xact_rdata` equals `expected_idcode`. A new `start` clears `done` and `success`.
- R9: An acknowledge other than 3'b001 gives `done`=1 and `success`=0.
- R10: A parity error reported with the read gives `success`=0, even when the data matches.
- R11: `idcode` holds the `xact_rdata` value sampled with `xact_done`, including when it does not match the expected value.
- R12: A `start` pulse while a sequence is running has no effect; the raw stream stays exactly as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin bring-up |
| clk_div | input | DIV_W | Half-period length minus one, in clk cycles |
| expected_idcode | input | 32 | Value the identification word must match |
| swclk | output | 1 | Serial wire clock to the target |
| swdio_out | output | 1 | Serial wire data driven by the host |
| swdio_oe | output | 1 | Host output enable for the data line |
| eng_swclk | input | 1 | Serial clock from the transaction engine |
| eng_swdio_out | input | 1 | Data from the transaction engine |
| eng_swdio_oe | input | 1 | Output enable from the transaction engine |
| xact_req | output | 1 | Read request to the engine, held until done |
| xact_apndp | output | 1 | Port select for the request (0 = DP) |
| xact_rnw | output | 1 | Direction of the request (1 = read) |
| xact_addr | output | 2 | Register address bits A[3:2] |
| xact_done | input | 1 | Engine signals the read has finished |
| xact_ack | input | 3 | Acknowledge code returned by the target |
| xact_parity_err | input | 1 | Engine detected a data parity error |
| xact_rdata | input | 32 | Word read from the target |
| done | output | 1 | Sequence has finished |
| success | output | 1 | Link is confirmed |
| idcode | output | 32 | Captured identification word |

## Verification
The checker watches several rules on every cycle:
- the data line holds steady while the clock is high during raw bits;
- the request holds until the engine completes, and rises only straight after the raw stream;
- a bad acknowledge or a parity error never yields success;
- success never appears without done;
- the lines stay quiet when the block is idle.

Other behaviour only the directed scenarios can show, by recording each bit at a rising clock edge: the content and length of the raw bit stream, the exact half-period length for different divider values, engine ownership of the lines, the captured word, and the rejection of a restart while the block is busy.

// File: rtl/swd_init_pkg.sv
package swd_init_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAW  = 2'd1,
        ST_READ = 2'd2,
        ST_DONE = 2'd3
    } init_state_e;

    localparam logic [2:0] ACK_OK      = 3'b001;
    localparam logic [1:0] IDCODE_ADDR = 2'b00;

    typedef struct packed {
        logic [2:0]  ack;
        logic        perr;
        logic [31:0] data;
    } xact_rsp_t;

    function automatic logic rsp_good(input xact_rsp_t rsp, input logic [31:0] expect_id);
        return (rsp.ack == ACK_OK) && !rsp.perr && (rsp.data == expect_id);
    endfunction

endpackage

// File: rtl/swd_half_tick.sv
module swd_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase,
    output logic             bit_end
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap    = (cnt == div);
    assign bit_end = run && wrap && phase;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swd_raw_stream.sv
module swd_raw_stream #(
    parameter int                     LR_BITS     = 56,
    parameter int                     IDLE_BITS   = 2,
    parameter int                     SWITCH_BITS = 16,
    parameter logic [SWITCH_BITS-1:0] SWITCH_PAT  = 16'hE79E
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic advance,
    output logic bit_val,
    output logic last
);
    localparam int TOTAL    = 2 * (LR_BITS + IDLE_BITS) + SWITCH_BITS;
    localparam int IDX_W    = $clog2(TOTAL + 1);
    localparam int SW_START = LR_BITS + IDLE_BITS;
    localparam int SW_END   = SW_START + SWITCH_BITS;
    localparam int LR2_END  = SW_END + LR_BITS;
    localparam int SW_IW    = (SWITCH_BITS > 1) ? $clog2(SWITCH_BITS) : 1;

    logic [IDX_W-1:0] idx;
    logic [SW_IW-1:0] sel;
    int               pos;

    always_ff @(posedge clk) begin
        if (rst || load)  idx <= '0;
        else if (advance) idx <= idx + 1'b1;
    end

    assign last = (idx == IDX_W'(TOTAL - 1));

    always_comb begin
        pos = int'(idx);
        sel = SW_IW'(pos - SW_START);
        if (pos < LR_BITS)       bit_val = 1'b1;
        else if (pos < SW_START) bit_val = 1'b0;
        else if (pos < SW_END)   bit_val = SWITCH_PAT[sel];
        else if (pos < LR2_END)  bit_val = 1'b1;
        else                     bit_val = 1'b0;
    end
endmodule

// File: rtl/swd_init_seq.sv
module swd_init_seq
    import swd_init_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int LR_BITS     = 56,
    parameter int IDLE_BITS   = 2,
    parameter int SWITCH_BITS = 16,
    parameter logic [SWITCH_BITS-1:0] SWITCH_PAT = 16'hE79E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [31:0]      expected_idcode,
    output logic             swclk,
    output logic             swdio_out,
    output logic             swdio_oe,
    input  logic             eng_swclk,
    input  logic             eng_swdio_out,
    input  logic             eng_swdio_oe,
    output logic             xact_req,
    output logic             xact_apndp,
    output logic             xact_rnw,
    output logic [1:0]       xact_addr,
    input  logic             xact_done,
    input  logic [2:0]       xact_ack,
    input  logic             xact_parity_err,
    input  logic [31:0]      xact_rdata,
    output logic             done,
    output logic             success,
    output logic [31:0]      idcode
);
    init_state_e st;
    logic        raw_active, eng_active, launch;
    logic        phase, bit_end, raw_bit, raw_last;
    xact_rsp_t   rsp;

    assign raw_active = (st == ST_RAW);
    assign eng_active = (st == ST_READ);
    assign launch     = start && (st == ST_IDLE || st == ST_DONE);
    assign rsp        = '{ack: xact_ack, perr: xact_parity_err, data: xact_rdata};

    swd_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (raw_active),
        .div     (clk_div),
        .phase   (phase),
        .bit_end (bit_end)
    );

    swd_raw_stream #(
        .LR_BITS     (LR_BITS),
        .IDLE_BITS   (IDLE_BITS),
        .SWITCH_BITS (SWITCH_BITS),
        .SWITCH_PAT  (SWITCH_PAT)
    ) u_raw (
        .clk     (clk),
        .rst     (rst),
        .load    (launch),
        .advance (bit_end),
        .bit_val (raw_bit),
        .last    (raw_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            done    <= 1'b0;
            success <= 1'b0;
            idcode  <= '0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: if (launch) begin
                    st      <= ST_RAW;
                    done    <= 1'b0;
                    success <= 1'b0;
                end
                ST_RAW: if (bit_end && raw_last) st <= ST_READ;
                ST_READ: if (xact_done) begin
                    st      <= ST_DONE;
                    done    <= 1'b1;
                    success <= rsp_good(rsp, expected_idcode);
                    idcode  <= rsp.data;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        if (raw_active) begin
            swclk     = phase;
            swdio_out = raw_bit;
            swdio_oe  = 1'b1;
        end else if (eng_active) begin
            swclk     = eng_swclk;
            swdio_out = eng_swdio_out;
            swdio_oe  = eng_swdio_oe;
        end else begin
            swclk     = 1'b0;
            swdio_out = 1'b0;
            swdio_oe  = 1'b1;
        end
    end

    assign xact_req   = eng_active;
    assign xact_apndp = 1'b0;
    assign xact_rnw   = 1'b1;
    assign xact_addr  = IDCODE_ADDR;
endmodule

// File: rtl/swd_init_checker.sv
module swd_init_checker (
    input logic       clk,
    input logic       rst,
    input logic       swclk,
    input logic       swdio_out,
    input logic       raw_active,
    input logic       eng_active,
    input logic       xact_req,
    input logic       xact_done,
    input logic [2:0] xact_ack,
    input logic       xact_parity_err,
    input logic       done,
    input logic       success
);
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!raw_active && !eng_active) |-> (!swclk && !swdio_out));

    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (raw_active && swclk && $past(swclk)) |-> $stable(swdio_out));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (xact_req && !xact_done) |=> xact_req);

    p_req_after_raw_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(xact_req) |-> $past(raw_active));

    p_success_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
        success |-> done);

    p_bad_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (xact_req && xact_done && xact_ack != 3'b001) |=> (done && !success));

    p_parity_r10: assert property (@(posedge clk) disable iff (rst)
        (xact_req && xact_done && xact_parity_err) |=> !success);
endmodule

bind swd_init_seq swd_init_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .swclk           (swclk),
    .swdio_out       (swdio_out),
    .raw_active      (raw_active),
    .eng_active      (eng_active),
    .xact_req        (xact_req),
    .xact_done       (xact_done),
    .xact_ack        (xact_ack),
    .xact_parity_err (xact_parity_err),
    .done            (done),
    .success         (success)
);

// File: tb/test_swd_init_seq.sv
module test_swd_init_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  clk_div = 8'd0;
    logic [31:0] expected_idcode = 32'h0;
    logic        swclk, swdio_out, swdio_oe;
    logic        eng_swclk = 1'b0, eng_swdio_out = 1'b0, eng_swdio_oe = 1'b0;
    logic        xact_req, xact_apndp, xact_rnw;
    logic [1:0]  xact_addr;
    logic        xact_done = 1'b0;
    logic [2:0]  xact_ack = 3'b000;
    logic        xact_parity_err = 1'b0;
    logic [31:0] xact_rdata = 32'h0;
    logic        done, success;
    logic [31:0] idcode;

    int checks = 0, failures = 0, cyc = 0;

    swd_init_seq i_swd_init_seq (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; failures++;
            $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Line monitor for the raw stream
    bit mon_en = 1'b0;
    bit bits [0:199];
    int nbits, hi_min, hi_max, hirun, hold_err, oe_err;
    logic prev_clk = 1'b0, prev_dio = 1'b0;

    always @(negedge clk) begin
        if (mon_en && !xact_req) begin
            if (swdio_oe !== 1'b1) oe_err++;
            if (swclk && !prev_clk) begin
                if (nbits < 200) bits[nbits] = swdio_out;
                nbits++;
                hirun = 1;
            end else if (swclk && prev_clk) begin
                hirun++;
                if (swdio_out !== prev_dio) hold_err++;
            end else if (!swclk && prev_clk) begin
                if (hirun < hi_min) hi_min = hirun;
                if (hirun > hi_max) hi_max = hirun;
            end
        end
        prev_clk = swclk;
        prev_dio = swdio_out;
    end

    function automatic bit exp_bit(input int i);
        logic [15:0] pat = 16'hE79E;
        if (i < 56) return 1'b1;
        if (i < 58) return 1'b0;
        if (i < 74) return pat[i-58];
        if (i < 130) return 1'b1;
        return 1'b0;
    endfunction

    task automatic run_seq(input logic [7:0] div, input logic [2:0] ack, input bit perr,
                           input logic [31:0] rd, input logic [31:0] expid, input bit poke);
        int n, e2, e3, e4;
        clk_div = div; expected_idcode = expid;
        eng_swclk = 1'b1; eng_swdio_out = 1'b1; eng_swdio_oe = 1'b0;
        nbits = 0; hi_min = 1000; hi_max = 0; hirun = 0; hold_err = 0; oe_err = 0;
        mon_en = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!done && !success, "R8 cleared by start", {30'b0, done, success}, 32'h0);
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        n = 0;
        while (!xact_req && n < 5000) begin @(negedge clk); n++; end
        mon_en = 1'b0;
        chk(nbits == 132, "R4 stream length", nbits, 132);
        e2 = 0; e3 = 0; e4 = 0;
        for (int i = 0; i < 132 && i < nbits; i++) begin
            if (bits[i] != exp_bit(i)) begin
                if (i < 58) e2++; else if (i < 74) e3++; else e4++;
            end
        end
        chk(e2 == 0, "R2 first line reset", e2, 0);
        chk(e3 == 0, "R3 switch word", e3, 0);
        chk(e4 == 0, "R4 second line reset", e4, 0);
        if (poke) chk(nbits == 132 && e2 + e3 + e4 == 0, "R12 restart ignored", nbits, 132);
        chk(hi_min == div + 1 && hi_max == div + 1, "R5 half period", hi_max, div + 1);
        chk(hold_err == 0, "R5 data stable high", hold_err, 0);
        chk(oe_err == 0, "R7 raw ignores engine oe", oe_err, 0);
        chk(!xact_apndp && xact_rnw && xact_addr == 2'b00, "R6 request fields",
            {29'b0, xact_apndp, xact_rnw, xact_addr}, 32'h4);
        chk(swclk && swdio_out && !swdio_oe, "R7 engine drives lines",
            {29'b0, swclk, swdio_out, swdio_oe}, 32'h6);
        eng_swclk = 1'b0; eng_swdio_out = 1'b0; eng_swdio_oe = 1'b1;
        repeat (4) @(negedge clk);
        chk(!swclk && !swdio_out && swdio_oe, "R7 engine follow",
            {29'b0, swclk, swdio_out, swdio_oe}, 32'h1);
        chk(xact_req && !done, "R6 request held", {30'b0, xact_req, done}, 32'h2);
        xact_ack = ack; xact_parity_err = perr; xact_rdata = rd; xact_done = 1'b1;
        @(negedge clk) xact_done = 1'b0;
        chk(!xact_req && done, "R6 request released / R8 done", {30'b0, xact_req, done}, 32'h1);
        chk(!swclk && !swdio_out && swdio_oe, "R1 quiet after read",
            {29'b0, swclk, swdio_out, swdio_oe}, 32'h1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!swclk && !swdio_out && swdio_oe && !xact_req, "R1 reset lines",
            {28'b0, swclk, swdio_out, swdio_oe, xact_req}, 32'h2);
        chk(!done && !success && idcode == 32'h0, "R1 reset status", idcode, 32'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!swclk && !xact_req && !done, "R1 idle", {29'b0, swclk, xact_req, done}, 32'h0);
    endtask

    task automatic t_good_fast;
        run_seq(8'd0, 3'b001, 1'b0, 32'h2BA01477, 32'h2BA01477, 1'b0);
        chk(success, "R8 success", success, 1);
        chk(idcode == 32'h2BA01477, "R11 capture", idcode, 32'h2BA01477);
    endtask

    task automatic t_slow_busy;
        run_seq(8'd3, 3'b001, 1'b0, 32'h0BC11477, 32'h0BC11477, 1'b1);
        chk(success && done, "R8 success slow", {30'b0, done, success}, 32'h3);
    endtask

    task automatic t_bad_ack;
        run_seq(8'd1, 3'b010, 1'b0, 32'h2BA01477, 32'h2BA01477, 1'b0);
        chk(done && !success, "R9 wait ack", {30'b0, done, success}, 32'h2);
        run_seq(8'd0, 3'b100, 1'b0, 32'h2BA01477, 32'h2BA01477, 1'b0);
        chk(done && !success, "R9 fault ack", {30'b0, done, success}, 32'h2);
    endtask

    task automatic t_parity;
        run_seq(8'd0, 3'b001, 1'b1, 32'h2BA01477, 32'h2BA01477, 1'b0);
        chk(done && !success, "R10 parity error", {30'b0, done, success}, 32'h2);
    endtask

    task automatic t_mismatch;
        run_seq(8'd2, 3'b001, 1'b0, 32'h12345678, 32'h2BA01477, 1'b0);
        chk(done && !success, "R11 mismatch fails", {30'b0, done, success}, 32'h2);
        chk(idcode == 32'h12345678, "R11 mismatch captured", idcode, 32'h12345678);
    endtask

    initial begin
        t_reset();
        t_good_fast();
        t_slow_busy();
        t_bad_ack();
        t_parity();
        t_mismatch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule